// File: doc/BRIEF.md
# Shared DRAM Host Window

This block sits between a 16-bit host bus and a 16-bit DRAM that a coprocessor also uses. It decodes host addresses into three regions. The first is a plain 128 KiB read/write window. It accepts byte and word accesses and drives a word-indexed DRAM port with byte enables. The other two are read-only 64 KiB aliases. Each applies a fixed bit permutation to the word index, so that graphics data stored in tile order comes out as a linear scan.

Word writes to the lower half of the plain window are also watched. A nonzero word written to either of two mailbox offsets releases a matching coprocessor wait flag. The data is still stored in DRAM. The coprocessor raises each flag through its own set input. The DRAM is external: the read path is combinational from `mem_rdata`, and writes commit on the rising clock edge while `mem_we` is high.

Top module: `shared_dram_window`

## Requirements
- R1: With `host_sel` high, an address in 0x300000–0x31FFFF is the plain window. A word access uses DRAM index `host_addr[16:1]`, and a word read returns that DRAM word. `host_hit` is high for any read or write there.
- R2: Byte accesses (`host_word`=0) to the plain window are big-endian. An even address selects bits 15:8 (`mem_be`=2'b10) and an odd address selects bits 7:0 (`mem_be`=2'b01). A byte write stores `host_wdata[7:0]` into that lane only. A byte read returns the lane zero-extended in `host_rdata[7:0]`.
- R3: A word read at 0x390000–0x39FFFF returns DRAM word p, where w = `host_addr[15:1]` and p is built as follows. p[0]=w[0], p[14:12]=w[14:12], p[11:7]=w[5:1] and p[6:1]=w[11:6].
- R4: A word read at 0x3A0000–0x3AFFFF returns DRAM word p, built as follows. p[0]=w[0], p[14:11]=w[14:11], p[10:7]=w[4:1] and p[6:1]=w[10:5].
- R5: Writes to either permuted view leave DRAM unchanged and give `host_hit`=0. Byte reads of a view return 0 with `host_hit`=0.
- R6: A nonzero word write to 0x30FE06 clears `wait_a` from the next cycle on. One to 0x30FE08 clears `wait_b`. In both cases the word is stored.
- R7: A clear is not caused by zero data, by a byte write, or by the same offsets in the upper half (0x31FE06, 0x31FE08).
- R8: Both flags are 0 after reset. A high `cp_set_a`/`cp_set_b` sets its flag in the next cycle. If a set and a clear arrive in the same cycle, the flag clears. With neither, the flag holds.
- R9: With `host_sel` low, or an address outside all three regions, there is no DRAM access. `host_hit` is 0 and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Region select qualifying the host access |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 16 | Host write data (byte writes use bits 7:0) |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe (takes precedence over read) |
| host_word | input | 1 | 1 = word access, 0 = byte access |
| host_rdata | output | 16 | Read data |
| host_hit | output | 1 | Access accepted by a region |
| mem_addr | output | 16 | DRAM word index |
| mem_re | output | 1 | DRAM read enable |
| mem_we | output | 1 | DRAM write enable (commits at clock edge) |
| mem_be | output | 2 | DRAM byte enables, bit 1 = bits 15:8 |
| mem_wdata | output | 16 | DRAM write data |
| mem_rdata | input | 16 | DRAM read data (combinational) |
| cp_set_a | input | 1 | Coprocessor raises wait flag A |
| cp_set_b | input | 1 | Coprocessor raises wait flag B |
| wait_a | output | 1 | Wait flag A |
| wait_b | output | 1 | Wait flag B |

## Verification
The bench uses the default parameters: a 24-bit bus, 17-bit plain window, 16-bit views and the mailbox offsets 0xFE06 and 0xFE08. With these, both views cover exactly 32K words, so every view address can be read against a DRAM model whose initial contents are all distinct. A match on every address shows that each permutation is a bijection. The 17-bit window also places the mailbox offsets in both halves, which lets the bench confirm that snooping applies to the lower half only.

// File: rtl/shw_pkg.sv
`timescale 1ns/1ps
// shw_pkg: shared types for the shared DRAM host window.
// Assumes a single host region decode yields one region per access.
package shw_pkg;
    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_PLAIN = 2'd1,
        RG_VIEW1 = 2'd2,
        RG_VIEW2 = 2'd3
    } region_e;

    localparam int FLAG_A = 0;
    localparam int FLAG_B = 1;
    localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/shw_decode.sv
`timescale 1ns/1ps
// shw_decode: classifies the upper host address bits into a region.
// Also reports whether a plain-window access falls in its lower half.
// Assumes PLAIN_LOG2 > TAG_LSB and that the regions do not overlap.
module shw_decode
    import shw_pkg::*;
#(
    parameter int              AW         = 24,
    parameter int              TAG_LSB    = 16,
    parameter int              PLAIN_LOG2 = 17,
    parameter logic [AW-1:0]   PLAIN_BASE = 24'h300000,
    parameter logic [AW-1:0]   VIEW1_BASE = 24'h390000,
    parameter logic [AW-1:0]   VIEW2_BASE = 24'h3A0000
) (
    input  logic               sel,
    input  logic [AW-1:TAG_LSB] addr_hi,
    output region_e            region,
    output logic               low_half
);
    localparam logic [AW-1:PLAIN_LOG2] PLAIN_TAG = PLAIN_BASE[AW-1:PLAIN_LOG2];
    localparam logic [AW-1:TAG_LSB]    V1_TAG    = VIEW1_BASE[AW-1:TAG_LSB];
    localparam logic [AW-1:TAG_LSB]    V2_TAG    = VIEW2_BASE[AW-1:TAG_LSB];

    // Region match, plain window first.
    always_comb begin
        region = RG_NONE;
        if (sel) begin
            if (addr_hi[AW-1:PLAIN_LOG2] == PLAIN_TAG) region = RG_PLAIN;
            else if (addr_hi == V1_TAG)                region = RG_VIEW1;
            else if (addr_hi == V2_TAG)                region = RG_VIEW2;
        end
    end

    // Lower-half indicator inside the plain window.
    assign low_half = (addr_hi[PLAIN_LOG2-1:TAG_LSB] == '0);
endmodule

// File: rtl/shw_cell_perm.sv
`timescale 1ns/1ps
// shw_cell_perm: pure wiring permutation of a word index for tile readout.
// Bit 0 and the bits above COL_W+ROW_W stay in place. The COL_W bits from
// bit 1 move up above the row field, and the ROW_W bits after them move
// down to bit 1. Assumes 1+COL_W+ROW_W <= IW.
module shw_cell_perm #(
    parameter int IW    = 15,
    parameter int COL_W = 5,
    parameter int ROW_W = 6
) (
    input  logic [IW-1:0] w,
    output logic [IW-1:0] idx
);
    localparam int KEEP_LSB = 1 + COL_W + ROW_W;

    // Bit 0 passes straight through.
    assign idx[0] = w[0];

    for (genvar c = 0; c < COL_W; c++) begin : g_col
        // Column bits move above the row field.
        assign idx[1 + ROW_W + c] = w[1 + c];
    end

    for (genvar r = 0; r < ROW_W; r++) begin : g_row
        // Row bits move down to the bottom.
        assign idx[1 + r] = w[1 + COL_W + r];
    end

    for (genvar k = KEEP_LSB; k < IW; k++) begin : g_keep
        // High bits keep their place.
        assign idx[k] = w[k];
    end
endmodule

// File: rtl/shw_wait_flags.sv
`timescale 1ns/1ps
// shw_wait_flags: coprocessor wait flags, set by the coprocessor and
// cleared by host mailbox writes. Clear beats set in the same cycle.
// Assumes set and clr are synchronous to clk.
module shw_wait_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    // Flag register update with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags | set) & ~clr;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> !flags[i]); // R8
        AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !clr[i]) |=> flags[i]); // R8
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!set[i] && !clr[i]) |=> $stable(flags[i])); // R8
    end
endmodule

// File: rtl/shared_dram_window.sv
`timescale 1ns/1ps
// shared_dram_window: host port onto a coprocessor's 16-bit DRAM.
// It provides a plain byte/word window and two read-only permuted views,
// and it snoops mailbox word writes to release coprocessor wait flags.
// Assumes a combinational DRAM read and DRAM writes that commit at the
// clock edge while mem_we is high. A write strobe takes precedence over a
// read strobe.
module shared_dram_window
    import shw_pkg::*;
#(
    parameter int            AW          = 24,
    parameter int            TAG_LSB     = 16,
    parameter int            PLAIN_LOG2  = 17,
    parameter logic [AW-1:0] PLAIN_BASE  = 24'h300000,
    parameter logic [AW-1:0] VIEW1_BASE  = 24'h390000,
    parameter logic [AW-1:0] VIEW2_BASE  = 24'h3A0000,
    parameter int            VIEW1_COL_W = 5,
    parameter int            VIEW2_COL_W = 4,
    parameter int            ROW_W       = 6,
    parameter logic [TAG_LSB-1:0] MBOX_A = 16'hFE06,
    parameter logic [TAG_LSB-1:0] MBOX_B = 16'hFE08
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic [23:0] host_addr,
    input  logic [15:0] host_wdata,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic        host_word,
    output logic [15:0] host_rdata,
    output logic        host_hit,
    output logic [15:0] mem_addr,
    output logic        mem_re,
    output logic        mem_we,
    output logic [1:0]  mem_be,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        cp_set_a,
    input  logic        cp_set_b,
    output logic        wait_a,
    output logic        wait_b
);
    localparam int MEM_AW  = PLAIN_LOG2 - 1;
    localparam int VIEW_IW = TAG_LSB - 1;
    localparam int PAD_W   = MEM_AW - VIEW_IW;

    region_e              region;
    logic                 low_half;
    logic [VIEW_IW-1:0]   view_w;
    logic [VIEW_IW-1:0]   view_idx [2];
    logic [NUM_FLAGS-1:0] snoop_clr;
    logic [NUM_FLAGS-1:0] flags;
    logic                 snoop_wr;

    shw_decode #(
        .AW(AW), .TAG_LSB(TAG_LSB), .PLAIN_LOG2(PLAIN_LOG2),
        .PLAIN_BASE(PLAIN_BASE), .VIEW1_BASE(VIEW1_BASE), .VIEW2_BASE(VIEW2_BASE)
    ) u_decode (
        .sel     (host_sel),
        .addr_hi (host_addr[AW-1:TAG_LSB]),
        .region  (region),
        .low_half(low_half)
    );

    assign view_w = host_addr[VIEW_IW:1];

    for (genvar g = 0; g < 2; g++) begin : g_view
        shw_cell_perm #(
            .IW(VIEW_IW), .COL_W(g == 0 ? VIEW1_COL_W : VIEW2_COL_W), .ROW_W(ROW_W)
        ) u_perm (
            .w  (view_w),
            .idx(view_idx[g])
        );
    end

    // DRAM port control per region and strobe.
    always_comb begin
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_be    = 2'b00;
        mem_wdata = '0;
        host_hit  = 1'b0;
        unique case (region)
            RG_PLAIN: begin
                mem_addr = host_addr[MEM_AW:1];
                host_hit = host_wr | host_rd;
                if (host_wr) begin
                    mem_we    = 1'b1;
                    mem_be    = host_word ? 2'b11 : (host_addr[0] ? 2'b01 : 2'b10);
                    mem_wdata = host_word ? host_wdata : {host_wdata[7:0], host_wdata[7:0]};
                end else if (host_rd) begin
                    mem_re = 1'b1;
                end
            end
            RG_VIEW1, RG_VIEW2: begin
                if (host_rd && host_word && !host_wr) begin
                    mem_re   = 1'b1;
                    host_hit = 1'b1;
                    mem_addr = {{PAD_W{1'b0}}, view_idx[region == RG_VIEW2 ? 1 : 0]};
                end
            end
            default: ;
        endcase
    end

    // Read data return with byte-lane selection.
    always_comb begin
        if (!mem_re)        host_rdata = '0;
        else if (host_word) host_rdata = mem_rdata;
        else if (host_addr[0]) host_rdata = {8'h00, mem_rdata[7:0]};
        else                host_rdata = {8'h00, mem_rdata[15:8]};
    end

    // Mailbox snoop on nonzero word writes to the lower half.
    always_comb begin
        snoop_wr = (region == RG_PLAIN) && low_half && host_wr && host_word
                   && (host_wdata != '0);
        snoop_clr[FLAG_A] = snoop_wr && (host_addr[TAG_LSB-1:0] == MBOX_A);
        snoop_clr[FLAG_B] = snoop_wr && (host_addr[TAG_LSB-1:0] == MBOX_B);
    end

    shw_wait_flags #(.N(NUM_FLAGS)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  ({cp_set_b, cp_set_a}),
        .clr  (snoop_clr),
        .flags(flags)
    );

    assign wait_a = flags[FLAG_A];
    assign wait_b = flags[FLAG_B];

    AST_VIEW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (region inside {RG_VIEW1, RG_VIEW2}) |-> !mem_we); // R5
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !host_word) |-> ($countones(mem_be) == 1)); // R2
    AST_SNOOP_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (|snoop_clr) |-> (mem_we && mem_be == 2'b11)); // R6
    AST_NO_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> (!mem_we && !mem_re && !host_hit)); // R9
endmodule

// File: tb/shared_dram_window_tb.sv
`timescale 1ns/1ps
module shared_dram_window_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_sel, host_rd, host_wr, host_word;
    logic [23:0] host_addr;
    logic [15:0] host_wdata, host_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        host_hit, mem_re, mem_we, cp_set_a, cp_set_b, wait_a, wait_b;
    logic [1:0]  mem_be;

    int n_cmp = 0;
    int n_bad = 0;
    int dram_gen = 0;
    logic exp_a = 1'b0;
    logic exp_b = 1'b0;
    logic [15:0] dram [int];
    logic [15:0] refm [int];

    always #2.5 clk = ~clk;

    shared_dram_window u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_wr(host_wr),
        .host_word(host_word), .host_rdata(host_rdata), .host_hit(host_hit),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cp_set_a(cp_set_a),
        .cp_set_b(cp_set_b), .wait_a(wait_a), .wait_b(wait_b)
    );

    function automatic logic [15:0] init_val(int idx);
        return 16'(idx) ^ 16'hA5A5;
    endfunction

    function automatic logic [15:0] dram_get(int idx);
        if (dram.exists(idx)) return dram[idx];
        return init_val(idx);
    endfunction

    function automatic logic [15:0] ref_get(int idx);
        if (refm.exists(idx)) return refm[idx];
        return init_val(idx);
    endfunction

    // Reference permutation, written from the field description.
    function automatic int perm(int w, int cw);
        int keep;
        keep = w & 32'h7FFF & ~((1 << (cw + 7)) - 1);
        return keep | (((w >> 1) & ((1 << cw) - 1)) << 7)
                    | (((w >> (1 + cw)) & 63) << 1) | (w & 1);
    endfunction

    // Behavioural DRAM: combinational read, edge write.
    always @(mem_addr or mem_re or dram_gen)
        mem_rdata = mem_re ? dram_get(int'(mem_addr)) : 16'h0000;

    always @(posedge clk) begin
        if (mem_we) begin
            automatic logic [15:0] cur;
            cur = dram_get(int'(mem_addr));
            if (mem_be[1]) cur[15:8] = mem_wdata[15:8];
            if (mem_be[0]) cur[7:0]  = mem_wdata[7:0];
            dram[int'(mem_addr)] = cur;
            dram_gen++;
        end
    end

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive, check outputs, then advance the reference model.
    task automatic bus_cycle(string tag, logic sel, logic rd, logic wr, logic word,
                             logic [23:0] a, logic [15:0] d, logic sa, logic sb);
        logic plain, v1, v2, ehit, clr_a, clr_b;
        logic [15:0] erd, cur;
        int idx;
        @(negedge clk);
        host_sel = sel; host_rd = rd; host_wr = wr; host_word = word;
        host_addr = a; host_wdata = d; cp_set_a = sa; cp_set_b = sb;
        #1;
        chk(tag, "wait_a", {15'b0, wait_a}, {15'b0, exp_a});
        chk(tag, "wait_b", {15'b0, wait_b}, {15'b0, exp_b});
        plain = sel && (a[23:17] == 7'h18);
        v1 = sel && (a[23:16] == 8'h39);
        v2 = sel && (a[23:16] == 8'h3A);
        idx = int'(a[16:1]);
        ehit = 1'b0; erd = 16'h0000;
        if (plain) begin
            ehit = rd | wr;
            if (rd && !wr) begin
                cur = ref_get(idx);
                erd = word ? cur : (a[0] ? {8'h00, cur[7:0]} : {8'h00, cur[15:8]});
            end
        end else if ((v1 || v2) && rd && !wr && word) begin
            ehit = 1'b1;
            erd = ref_get(perm(int'(a[15:1]), v1 ? 5 : 4));
        end
        chk(tag, "host_rdata", erd, host_rdata);
        chk(tag, "host_hit", {15'b0, host_hit}, {15'b0, ehit});
        if (plain && wr) begin
            cur = ref_get(idx);
            if (word)      cur = d;
            else if (a[0]) cur[7:0] = d[7:0];
            else           cur[15:8] = d[7:0];
            refm[idx] = cur;
        end
        clr_a = plain && wr && word && !a[16] && d != 0 && a[15:0] == 16'hFE06;
        clr_b = plain && wr && word && !a[16] && d != 0 && a[15:0] == 16'hFE08;
        exp_a = clr_a ? 1'b0 : (sa ? 1'b1 : exp_a);
        exp_b = clr_b ? 1'b0 : (sb ? 1'b1 : exp_b);
    endtask

    task automatic idle(string tag);
        bus_cycle(tag, 0, 0, 0, 1, 24'h0, 16'h0, 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: got 190000 cycles expected earlier end");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; host_sel = 0; host_rd = 0; host_wr = 0; host_word = 1;
        host_addr = 0; host_wdata = 0; cp_set_a = 0; cp_set_b = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        chk("R8", "reset wait_a", {15'b0, wait_a}, 16'h0);
        chk("R8", "reset wait_b", {15'b0, wait_b}, 16'h0);
        chk("R9", "reset host_hit", {15'b0, host_hit}, 16'h0);

        bus_cycle("R8", 0, 0, 0, 1, 24'h0, 16'h0, 1, 0);          // set A
        bus_cycle("R7", 1, 0, 1, 1, 24'h30FE06, 16'h0000, 0, 0);  // zero data
        bus_cycle("R7", 1, 0, 1, 0, 24'h30FE06, 16'h00FF, 0, 0);  // byte write
        bus_cycle("R7", 1, 0, 1, 1, 24'h31FE06, 16'h1234, 0, 0);  // upper half
        bus_cycle("R6", 1, 0, 1, 1, 24'h30FE06, 16'hBEEF, 0, 1);  // clear A, set B
        bus_cycle("R6", 1, 1, 0, 1, 24'h30FE06, 16'h0, 0, 0);     // stored
        bus_cycle("R8", 1, 0, 1, 1, 24'h30FE08, 16'h0001, 0, 1);  // clear beats set
        bus_cycle("R6", 1, 1, 0, 1, 24'h30FE08, 16'h0, 1, 0);
        bus_cycle("R7", 1, 0, 1, 1, 24'h31FE08, 16'h5555, 0, 1);
        bus_cycle("R6", 1, 0, 1, 1, 24'h30FE08, 16'h8000, 0, 0);  // clear B only
        bus_cycle("R2", 1, 0, 1, 0, 24'h300010, 16'h00AB, 0, 0);
        bus_cycle("R2", 1, 0, 1, 0, 24'h300011, 16'h00CD, 0, 0);
        bus_cycle("R2", 1, 1, 0, 1, 24'h300010, 16'h0, 0, 0);
        bus_cycle("R2", 1, 1, 0, 0, 24'h300011, 16'h0, 0, 0);
        bus_cycle("R2", 1, 1, 0, 0, 24'h300010, 16'h0, 0, 0);
        bus_cycle("R1", 1, 0, 1, 1, 24'h31FFFE, 16'h4321, 0, 0);
        bus_cycle("R1", 1, 1, 0, 1, 24'h31FFFE, 16'h0, 0, 0);
        bus_cycle("R5", 1, 0, 1, 1, 24'h390002, 16'h7777, 0, 0);
        bus_cycle("R5", 1, 0, 1, 1, 24'h3A0002, 16'h6666, 0, 0);
        bus_cycle("R5", 1, 1, 0, 1, 24'h300000 | 24'(perm(1, 5) << 1), 16'h0, 0, 0);
        bus_cycle("R5", 1, 1, 0, 1, 24'h300000 | 24'(perm(1, 4) << 1), 16'h0, 0, 0);
        bus_cycle("R5", 1, 1, 0, 0, 24'h390004, 16'h0, 0, 0);
        bus_cycle("R9", 0, 1, 0, 1, 24'h300010, 16'h0, 0, 0);
        bus_cycle("R9", 1, 1, 0, 1, 24'h320000, 16'h0, 0, 0);
        bus_cycle("R9", 1, 0, 1, 1, 24'h3B0000, 16'hFFFF, 0, 0);

        // Random mix against the reference model.
        for (int i = 0; i < 3000; i++) begin
            automatic int k = int'($urandom % 8);
            automatic int widx = int'(($urandom % 2) ? ($urandom % 64) : (32'hFF00 | ($urandom % 64)))
                                 | int'(($urandom % 2) << 15);
            automatic logic [23:0] pa = 24'h300000 | 24'(widx << 1);
            automatic logic [15:0] d = 16'($urandom);
            automatic logic sa = ($urandom % 4) == 0;
            automatic logic sb = ($urandom % 4) == 0;
            automatic logic [23:0] va = (($urandom % 2) ? 24'h390000 : 24'h3A0000)
                                        | 24'(($urandom % 32768) << 1);
            case (k)
                0: bus_cycle("R1", 1, 0, 1, 1, pa, d, sa, sb);
                1: bus_cycle("R1", 1, 1, 0, 1, pa, d, sa, sb);
                2: bus_cycle("R2", 1, 0, 1, 0, pa | 24'($urandom % 2), d, sa, sb);
                3: bus_cycle("R2", 1, 1, 0, 0, pa | 24'($urandom % 2), d, sa, sb);
                4: bus_cycle("R5", 1, 0, 1, 1, va, d, sa, sb);
                5: bus_cycle("R3", 1, 1, 0, 1, va, d, sa, sb);
                6: bus_cycle("R9", $urandom % 2 == 0, 1, 0, 1, 24'h400000 | 24'($urandom % 65536), d, sa, sb);
                default: bus_cycle("R6", 1, 0, 1, 1,
                            (($urandom % 4) == 0 ? 24'h31FE00 : 24'h30FE00) | (($urandom % 2) ? 24'h6 : 24'h8),
                            ($urandom % 3) == 0 ? 16'h0 : d, sa, sb);
            endcase
        end

        // Exhaustive view sweeps: distinct DRAM contents make this a bijection check.
        for (int w = 0; w < 32768; w++)
            bus_cycle("R3", 1, 1, 0, 1, 24'h390000 | 24'(w << 1), 16'h0, 0, 0);
        for (int w = 0; w < 32768; w++)
            bus_cycle("R4", 1, 1, 0, 1, 24'h3A0000 | 24'(w << 1), 16'h0, 0, 0);
        idle("R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule